// File: doc/BRIEF.md
# Grouped Interrupt Flag Register Bank

This block stores pending-interrupt flags for twelve interrupt groups. Each group holds eight sources. A one-cycle pulse from a hardware source sets its flag. A flag clears in one of two ways: the CPU writes a 0 to its bit position, or the interrupt controller signals the vector fetch that services that exact group and source. The CPU cannot create a pending flag, because writing a 1 does nothing.

Each group has its own 16-bit word on a simple read/write bus. Reads are combinational and reflect the flags held after the last clock edge. Each group also drives a registered request line, which is the OR of its eight flags, toward the CPU interrupt input. Masking, acknowledge gating, source priority and vector storage belong to neighbouring logic.

When hardware and the CPU act on the same bit in the same cycle, the hardware action wins. When a source pulse and a vector-fetch clear hit the same bit, the new pulse wins, so no fresh event is lost.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset every flag reads 0 and every group request output is 0.
- R2: Bus word offset g (0 to 11) holds the flags of group g+1. Bit k (0 to 7) of that word is source k+1 of the group, which is input bit `src_pulse[g*8+k]`. Reads are combinational, so a read shows the flags held after the most recent clock edge.
- R3: Bits 15 to 8 of every word always read 0. Offsets 12 to 15 read as 0, and writes to those offsets change no flag.
- R4: A 1 on `src_pulse[i]` at a clock edge sets flag i, and the flag stays set until it is cleared.
- R5: A bus write with a 0 in bit k of a mapped word clears that flag at the edge. A 1 in bit k leaves the flag unchanged.
- R6: A vector-fetch strobe with group index g (0 to 11 meaning groups 1 to 12) and source index s (0 to 7) clears only flag g*8+s. A group index of 12 to 15 clears nothing.
- R7: A source pulse and a bus write of 0 to the same bit in the same cycle leave the flag set.
- R8: A source pulse and a vector-fetch clear of the same bit in the same cycle leave the flag set.
- R9: Request output g equals the OR of group g's eight flags as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| src_pulse | input | 96 | Hardware set strobes, bit g*8+k for group g+1 source k+1 |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 4 | Bus word offset |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data for `bus_addr` |
| vf_strobe | input | 1 | Vector-fetch clear strobe |
| vf_group | input | 4 | Group index of the serviced interrupt |
| vf_src | input | 3 | Source index of the serviced interrupt |
| grp_req | output | 12 | Per-group pending request |

## Verification
Any set or clear driven before a rising edge shows on `bus_rdata` right after that edge, because the read path has no register. The request line lags by one more edge. For each stimulus, the bench drives inputs, waits for the edge and updates its flag model. At the following falling edge it compares all sixteen read offsets against the model and compares `grp_req` against the OR of the flags held before the edge. Directed cycles force the collisions and out-of-range indices, and seeded random cycles then mix all strobes together.

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
  parameter int NGRP = 12,
  parameter int NSRC = 8,
  parameter int DW   = 16,
  parameter int AW   = 4,
  parameter int GW   = 4,
  parameter int SW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NGRP*NSRC-1:0] src_pulse,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic                 vf_strobe,
  input  logic [GW-1:0]        vf_group,
  input  logic [SW-1:0]        vf_src,
  output logic [NGRP-1:0]      grp_req
);
  localparam int NF = NGRP * NSRC;

  logic [NF-1:0]   flags, flags_nxt;
  logic [NGRP-1:0] any_set;

  always_comb begin
    flags_nxt = flags;
    for (int g = 0; g < NGRP; g++) begin
      for (int s = 0; s < NSRC; s++) begin
        if (src_pulse[g*NSRC+s])
          flags_nxt[g*NSRC+s] = 1'b1;
        else if (vf_strobe && vf_group == GW'(g) && vf_src == SW'(s))
          flags_nxt[g*NSRC+s] = 1'b0;
        else if (bus_we && bus_addr == AW'(g) && !bus_wdata[s])
          flags_nxt[g*NSRC+s] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_nxt;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NGRP; gi++) begin : g_any
      assign any_set[gi] = |flags[gi*NSRC +: NSRC];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_req <= '0;
    else        grp_req <= any_set;
  end

  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < NGRP; g++)
      if (bus_addr == AW'(g)) bus_rdata[NSRC-1:0] = flags[g*NSRC +: NSRC];
  end
endmodule

module irq_flag_bank_chk #(
  parameter int NGRP = 12,
  parameter int NSRC = 8,
  parameter int DW   = 16,
  parameter int GW   = 4,
  parameter int SW   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NGRP*NSRC-1:0] src_pulse,
  input logic                 vf_strobe,
  input logic [GW-1:0]        vf_group,
  input logic [SW-1:0]        vf_src,
  input logic [DW-1:0]        bus_rdata,
  input logic [NGRP-1:0]      grp_req,
  input logic [NGRP*NSRC-1:0] flags
);
  localparam int NF = NGRP * NSRC;
  localparam int IW = $clog2(NF);

  logic [NGRP-1:0] any_f;
  logic [IW-1:0]   vidx;
  assign vidx = IW'(32'(vf_group) * NSRC + 32'(vf_src));

  genvar gi;
  generate
    for (gi = 0; gi < NGRP; gi++) begin : g_or
      assign any_f[gi] = |flags[gi*NSRC +: NSRC];
    end
  endgenerate

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NSRC] == '0);

  // R4
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(src_pulse)) == $past(src_pulse)));

  // R5
  no_soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(src_pulse)) == '0));

  // R6
  vf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vf_strobe && vf_group < GW'(NGRP) && !src_pulse[vidx]) |=> !flags[$past(vidx)]);

  // R9
  req_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (grp_req == $past(any_f)));
endmodule

bind irq_flag_bank irq_flag_bank_chk #(
  .NGRP(NGRP), .NSRC(NSRC), .DW(DW), .GW(GW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .vf_strobe(vf_strobe),
  .vf_group(vf_group), .vf_src(vf_src), .bus_rdata(bus_rdata),
  .grp_req(grp_req), .flags(flags)
);

// File: tb/irq_flag_bank_bench.sv
`timescale 1ns/1ps
module irq_flag_bank_bench;
  localparam int NG = 12, NS = 8, NF = NG * NS;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NF-1:0] src_pulse = '0;
  logic          bus_we = 1'b0, vf_strobe = 1'b0;
  logic [3:0]    bus_addr = '0, vf_group = '0;
  logic [15:0]   bus_wdata = '0;
  logic [2:0]    vf_src = '0;
  logic [15:0]   bus_rdata;
  logic [NG-1:0] grp_req;

  int tests = 0, fails = 0;
  logic [NS-1:0] m [NG];
  logic [NG-1:0] mreq;

  irq_flag_bank u_irq_flag_bank (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .vf_strobe(vf_strobe), .vf_group(vf_group), .vf_src(vf_src), .grp_req(grp_req)
  );

  always #10 clk = ~clk;

  function automatic logic next_bit(input logic cur, input logic s, input logic vhit, input logic w0);
    if (s) return 1'b1;
    if (vhit || w0) return 1'b0;
    return cur;
  endfunction

  task automatic check16(input logic [15:0] act, input logic [15:0] exp, input string tag, input int a);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s offset %0d: actual %h expected %h", tag, a, act, exp);
    end
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 16; a++) begin
      bus_addr = 4'(a);
      #0.5;
      if (a < NG) check16(bus_rdata, {8'h00, m[a]}, tag, a);
      else        check16(bus_rdata, 16'h0000, "R3", a);
    end
    tests++;
    if (grp_req !== mreq) begin
      fails++;
      $display("FAIL R9 grp_req: actual %h expected %h", grp_req, mreq);
    end
  endtask

  task automatic cycle(input logic [NF-1:0] s, input logic we, input logic [3:0] a,
                       input logic [15:0] d, input logic v, input logic [3:0] vg,
                       input logic [2:0] vs, input string tag);
    logic [NS-1:0] n [NG];
    logic [NG-1:0] r;
    src_pulse = s; bus_we = we; bus_addr = a; bus_wdata = d;
    vf_strobe = v; vf_group = vg; vf_src = vs;
    for (int g = 0; g < NG; g++) begin
      r[g] = |m[g];
      for (int k = 0; k < NS; k++)
        n[g][k] = next_bit(m[g][k], s[g*NS+k], v && vg == 4'(g) && vs == 3'(k),
                           we && a == 4'(g) && !d[k]);
    end
    @(posedge clk);
    #1;
    src_pulse = '0; bus_we = 1'b0; vf_strobe = 1'b0;
    for (int g = 0; g < NG; g++) m[g] = n[g];
    mreq = r;
    @(negedge clk);
    sweep(tag);
  endtask

  function automatic logic [NF-1:0] onehot(input int i);
    logic [NF-1:0] v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [NF-1:0] rs;
    void'($urandom(32'd20240611));
    for (int g = 0; g < NG; g++) m[g] = '0;
    mreq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep("R1");

    // R4: first and last source of the bank
    cycle(onehot(0) | onehot(95), 1'b0, 4'd0, 16'h0, 1'b0, 4'd0, 3'd0, "R4");
    cycle('0, 1'b0, 4'd0, 16'h0, 1'b0, 4'd0, 3'd0, "R4");
    // R5: writing ones leaves flags, writing zero clears one bit
    cycle(onehot(1) | onehot(2), 1'b0, 4'd0, 16'h0, 1'b0, 4'd0, 3'd0, "R4");
    cycle('0, 1'b1, 4'd0, 16'hFFFF, 1'b0, 4'd0, 3'd0, "R5");
    cycle('0, 1'b1, 4'd0, 16'hFFFE, 1'b0, 4'd0, 3'd0, "R5");
    // R6: vector fetch clears only group 12 source 8
    cycle(onehot(94), 1'b0, 4'd0, 16'h0, 1'b0, 4'd0, 3'd0, "R4");
    cycle('0, 1'b0, 4'd0, 16'h0, 1'b1, 4'd11, 3'd7, "R6");
    cycle('0, 1'b0, 4'd0, 16'h0, 1'b1, 4'd13, 3'd6, "R6");
    // R7: set beats write-zero
    cycle(onehot(8), 1'b1, 4'd1, 16'h0000, 1'b0, 4'd0, 3'd0, "R7");
    // R8: set beats vector-fetch clear
    cycle(onehot(8), 1'b0, 4'd0, 16'h0, 1'b1, 4'd1, 3'd0, "R8");
    // R3: unmapped write touches nothing
    cycle('0, 1'b1, 4'd13, 16'h0000, 1'b0, 4'd0, 3'd0, "R3");
    cycle('0, 1'b1, 4'd12, 16'h0000, 1'b0, 4'd0, 3'd0, "R3");

    for (int t = 0; t < 2000; t++) begin
      for (int i = 0; i < NF; i++) rs[i] = ($urandom % 16) == 0;
      cycle(rs, ($urandom % 2) == 0, 4'($urandom), 16'($urandom | $urandom),
            ($urandom % 3) == 0, 4'($urandom), 3'($urandom), "R2");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule